// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

The block watches up to 32 external input lines. Each line is synchronised to the system clock and then fed to its own edge detector. Per line, software chooses whether a rising transition, a falling transition, both or neither count as an edge. A detected edge latches a per-line pending flag. Pending flags on unmasked lines combine into a single interrupt request. Lines whose event enable is set also produce a one-clock wake-up pulse when they detect an edge. This pulse does not depend on the interrupt mask.

Software reaches six 32-bit registers through a plain write strobe and a word index. Reads are combinational. Pending bits are cleared by writing a one to them. Software can also force a line pending through a write-only trigger register. Bits above the implemented line count always read as zero, so writing all ones to a register and reading it back shows how many lines exist.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset every register reads zero, and `irq_o` and `wake_o` are low.
- R2: When a line's bit is set in the rising-select register (word 2), a 0-to-1 change on that line sets its bit in the pending register (word 5).
- R3: When a line's bit is set in the falling-select register (word 3), a 1-to-0 change on that line sets its pending bit.
- R4: A line with both select bits set becomes pending on either transition. A transition the line has not selected never sets its pending bit.
- R5: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged.
- R6: `irq_o` is high exactly when some line has both its pending bit and its bit in the interrupt-enable register (word 0) set.
- R7: `wake_o` pulses high for one clock when a line with its bit set in the event-enable register (word 1) detects an edge. This happens even when the line's interrupt is masked.
- R8: Bits at positions NLINES and above read as zero in every register, and writes to them have no effect.
- R9: Writing 1 to a bit of the software-trigger register (word 4) sets that line's pending bit on the same clock edge. The software-trigger register reads as zero.
- R10: A line change made between clock edges shows in the pending register after the third rising clock edge, not earlier.
- R11: If an edge is detected on a line in the same cycle that a clear-write hits that line, the line stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_i | input | NLINES | External input lines, asynchronous |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Word index: 0 irq enable, 1 event enable, 2 rising select, 3 falling select, 4 software trigger, 5 pending |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the word at `addr` |
| irq_o | output | 1 | Combined interrupt request |
| wake_o | output | 1 | Wake-up event pulse |

## Verification
The edge logic is driven with a rising step, a falling step and an up-and-down pulse on lines configured rising-only, falling-only, both and none. This separates a swapped or missing polarity from a detector that ignores the select bits. The pending register is sampled after each of the first three clock edges following a line change, which exposes a missing or extra synchroniser stage. A clear-write is placed in the very cycle an edge is detected, and a software trigger is issued with no line activity, so the set-over-clear priority and the software path are tried apart from normal edges. Masked-but-event-enabled lines separate the wake path from the interrupt path.

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl #(
  parameter int NLINES = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] line_i,
  input  logic              wr_en,
  input  logic [2:0]        addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq_o,
  output logic              wake_o
);
  localparam logic [2:0] A_IEN  = 3'd0;
  localparam logic [2:0] A_EEN  = 3'd1;
  localparam logic [2:0] A_RISE = 3'd2;
  localparam logic [2:0] A_FALL = 3'd3;
  localparam logic [2:0] A_SWT  = 3'd4;
  localparam logic [2:0] A_PEND = 3'd5;

  logic [NLINES-1:0] ien, een, rsel, fsel, pend;
  logic [NLINES-1:0] sy1, sy2, sy3;
  logic [NLINES-1:0] wd, hit, sw_set, clr;
  logic              unused_wbits;

  assign wd           = wdata[NLINES-1:0];
  assign unused_wbits = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1 <= '0;
      sy2 <= '0;
      sy3 <= '0;
    end else begin
      sy1 <= line_i;
      sy2 <= sy1;
      sy3 <= sy2;
    end
  end

  assign hit    = (rsel & sy2 & ~sy3) | (fsel & ~sy2 & sy3);
  assign sw_set = (wr_en && addr == A_SWT)  ? wd : '0;
  assign clr    = (wr_en && addr == A_PEND) ? wd : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien  <= '0;
      een  <= '0;
      rsel <= '0;
      fsel <= '0;
    end else if (wr_en) begin
      case (addr)
        A_IEN:   ien  <= wd;
        A_EEN:   een  <= wd;
        A_RISE:  rsel <= wd;
        A_FALL:  fsel <= wd;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= '0;
      wake_o <= 1'b0;
    end else begin
      pend   <= (pend & ~clr) | hit | sw_set;
      wake_o <= |(hit & een);
    end
  end

  assign irq_o = |(pend & ien);

  always_comb begin
    case (addr)
      A_IEN:   rdata = 32'(ien);
      A_EEN:   rdata = 32'(een);
      A_RISE:  rdata = 32'(rsel);
      A_FALL:  rdata = 32'(fsel);
      A_PEND:  rdata = 32'(pend);
      default: rdata = 32'd0;
    endcase
  end

  // R5
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == A_PEND) |=> ((pend & $past(pend)) == $past(pend)));

  // R11
  edge_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> ((pend & $past(hit)) == $past(hit)));

  // R7
  wake_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (pend != '0));

  // R8
  rdata_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (64'(rdata) >> NLINES) == 64'd0);
endmodule

// File: tb/ext_irq_ctrl_bench.sv
module ext_irq_ctrl_bench;
  localparam int N = 23;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [N-1:0] line_i = '0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq_o, wake_o;
  int nchk = 0, nfail = 0;
  logic [31:0] v;

  always #5 clk = ~clk;

  ext_irq_ctrl #(.NLINES(N)) u_ext_irq_ctrl (.clk, .rst_n, .line_i, .wr_en,
    .addr, .wdata, .rdata, .irq_o, .wake_o);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic settle(); repeat (4) @(negedge clk); endtask

  task automatic t_reset();
    for (int a = 0; a < 6; a++) begin rd(3'(a), v); chk("R1 reg", v, 0); end
    chk("R1 irq_o", 32'(irq_o), 0);
    chk("R1 wake_o", 32'(wake_o), 0);
  endtask

  task automatic t_count();
    wr(3'd2, 32'hFFFF_FFFF); rd(3'd2, v); chk("R8 rise count", v, 32'h007F_FFFF);
    wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, v); chk("R8 ien count", v, 32'h007F_FFFF);
    wr(3'd2, 0); wr(3'd0, 0);
  endtask

  task automatic t_rise();
    wr(3'd2, 32'h8); wr(3'd0, 32'h8);
    @(negedge clk); line_i[3] = 1;
    @(negedge clk); rd(3'd5, v); chk("R10 after 1 edge", v, 0);
    @(negedge clk); rd(3'd5, v); chk("R10 after 2 edges", v, 0);
    @(negedge clk); rd(3'd5, v); chk("R2 R10 after 3 edges", v, 32'h8);
    chk("R6 irq on", 32'(irq_o), 1);
    wr(3'd5, 32'h0); rd(3'd5, v); chk("R5 write zero", v, 32'h8);
    wr(3'd5, 32'h8); rd(3'd5, v); chk("R5 write one", v, 0);
    chk("R6 irq off", 32'(irq_o), 0);
    line_i[3] = 0; settle(); rd(3'd5, v); chk("R4 fall ignored on rise-only", v, 0);
    line_i[5] = 1; settle(); line_i[5] = 0; settle();
    rd(3'd5, v); chk("R4 unselected line", v, 0);
    wr(3'd2, 0); wr(3'd0, 0);
  endtask

  task automatic t_fall();
    line_i[7] = 1; settle();
    wr(3'd3, 32'h80);
    rd(3'd5, v); chk("R4 rise ignored on fall-only", v, 0);
    @(negedge clk); line_i[7] = 0;
    repeat (3) @(negedge clk); rd(3'd5, v); chk("R3 fall", v, 32'h80);
    wr(3'd5, 32'h80); wr(3'd3, 0);
  endtask

  task automatic t_both();
    wr(3'd2, 32'h400); wr(3'd3, 32'h400);
    line_i[10] = 1; settle(); rd(3'd5, v); chk("R4 both rise", v, 32'h400);
    wr(3'd5, 32'h400);
    line_i[10] = 0; settle(); rd(3'd5, v); chk("R4 both fall", v, 32'h400);
    wr(3'd5, 32'h400); wr(3'd2, 0); wr(3'd3, 0);
  endtask

  task automatic t_mask();
    wr(3'd4, 32'h2); rd(3'd5, v); chk("R9 sw set", v, 32'h2);
    chk("R6 masked", 32'(irq_o), 0);
    wr(3'd0, 32'h2); chk("R6 unmasked", 32'(irq_o), 1);
    wr(3'd0, 32'h1); chk("R6 other line", 32'(irq_o), 0);
    rd(3'd4, v); chk("R9 sw reads zero", v, 0);
    wr(3'd4, 32'h4000_0000); rd(3'd5, v); chk("R8 sw high bit", v, 32'h2);
    wr(3'd5, 32'h2); wr(3'd0, 0);
  endtask

  task automatic t_wake();
    wr(3'd1, 32'h1000); wr(3'd2, 32'h1000);
    @(negedge clk); line_i[12] = 1;
    @(negedge clk); @(negedge clk);
    chk("R7 no early wake", 32'(wake_o), 0);
    @(negedge clk); chk("R7 wake pulse", 32'(wake_o), 1);
    chk("R7 irq stays masked", 32'(irq_o), 0);
    @(negedge clk); chk("R7 wake one clock", 32'(wake_o), 0);
    wr(3'd5, 32'h1000); wr(3'd1, 0); wr(3'd2, 0);
  endtask

  task automatic t_race();
    wr(3'd2, 32'h10_0000);
    wr(3'd4, 32'h10_0000);
    @(negedge clk); line_i[20] = 1;
    @(negedge clk);
    @(negedge clk); wr_en = 1; addr = 3'd5; wdata = 32'h10_0000;
    @(negedge clk); wr_en = 0;
    rd(3'd5, v); chk("R11 set beats clear", v, 32'h10_0000);
    wr(3'd5, 32'h10_0000); rd(3'd5, v); chk("R5 later clear", v, 0);
    wr(3'd2, 0);
  endtask

  initial begin
    #2_000_000;
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset(); t_count(); t_rise(); t_fall(); t_both();
    t_mask(); t_wake(); t_race();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule